// File: doc/BRIEF.md
# Floating-Point Exception Arbiter

This block decides what happens to the result of one floating-point operation once the arithmetic is done. It does not compute anything itself. A separate datapath supplies the operation kind, the class and sign of each operand, and the raw status flags it produced while rounding. From these the arbiter decides three things. It decides whether the result may be written to the destination register. It decides whether that write must be replaced by the default quiet NaN. It decides whether the operation raises a trap. It also records the cause of the outcome in a 32-bit control register, which software can read and write.

The decision is purely combinational and is valid in the same cycle as the operation strobe `op_valid`. Cause bits are replaced on the clock edge that ends a strobed cycle, so they show the outcome of the most recent operation only. The enable bits in the same register select which exceptions trap.

Operation kinds on `op_kind`:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | sub |
| 2 | mul |
| 3 | div |
| 4 | multiply-add |
| 5 | multiply-subtract |

Operand classes on `*_cls`:

| Code | Class |
|------|-------|
| 0 | zero |
| 1 | finite number |
| 2 | infinity |
| 3 | quiet NaN |
| 4 | signalling NaN |

Top module: `fp_exc_arbiter`

## Requirements
- R1: A synchronous reset clears the control register to 0. While `op_valid` is low, `res_we`, `res_force_qnan` and `trap_req` are all 0.
- R2: The control register is laid out as follows. Cause bits are at [4:0], in the order inexact=0, underflow=1, overflow=2, divide-by-zero=3, invalid=4. Trap enable bits are at [12:8], in the same order. All other bits read as 0. A cycle with `csr_we` high loads both fields from `csr_wdata`, and the new value is readable in the following cycle.
- R3: Every strobed operation replaces the whole cause field with its own outcome, which may be no cause at all. The new field is readable in the cycle after the strobe. Without `op_valid` or `csr_we`, the register holds its value.
- R4: A signalling NaN in any operand that the operation uses is invalid. Operands a and b are used by every operation. Operand c is used only by multiply-add and multiply-subtract, and is ignored by all other operations.
- R5: Adding two infinities of opposite sign is invalid. Subtracting two infinities of the same sign is invalid. The other sign combinations of infinities are not invalid.
- R6: For mul, multiply-add and multiply-subtract, infinity times zero in either order is invalid. For div, infinity divided by infinity and zero divided by zero are invalid.
- R7: In multiply-add, the operation is invalid when the product a*b is infinite and c is an infinity of the opposite sign. In multiply-subtract, it is invalid when c is an infinity of the same sign. The product is infinite when a or b is infinite and both are finite or infinite. Its sign is the XOR of the operand signs.
- R8: An invalid operation with the invalid trap enabled sets only the invalid cause and suppresses the write. With the trap disabled, it writes the default quiet NaN (`res_we` and `res_force_qnan` both high) and sets no cause.
- R9: A finite number divided by zero, with the divide-by-zero trap enabled, sets only that cause and suppresses the write. With the trap disabled, the operation is resolved from the raw status like any other operation.
- R10: When the operation is not trapped under R8 or R9, the raw status (bits: inexact=0, rounded=1, denormal=2, underflow=3, overflow=4) is resolved by priority. Overflow comes first, if its trap is enabled. Underflow or denormal comes next, if the underflow trap is enabled. Inexact or rounded comes last, if the inexact trap is enabled. Only the first match is recorded, and the write happens only when nothing matched.
- R11: `trap_req` is high in the strobe cycle exactly when the operation sets a cause. A write is never enabled together with a trap.
- R12: When `csr_we` and `op_valid` are high in the same cycle, the decision uses the enables held before that cycle. The register then takes its enables from `csr_wdata` and its causes from the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_we | input | 1 | Software write strobe for the control register |
| csr_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Control register read value |
| op_valid | input | 1 | Operation strobe; the other operation inputs are valid |
| op_kind | input | 3 | Operation code (0..5) |
| a_cls | input | 3 | Class of operand a (multiplicand or first source) |
| a_neg | input | 1 | Sign of operand a |
| b_cls | input | 3 | Class of operand b |
| b_neg | input | 1 | Sign of operand b |
| c_cls | input | 3 | Class of operand c (addend of the fused forms) |
| c_neg | input | 1 | Sign of operand c |
| raw_status | input | 5 | Raw status flags from the datapath |
| res_we | output | 1 | Result register write enable |
| res_force_qnan | output | 1 | Replace the written result by the default quiet NaN |
| trap_req | output | 1 | Operation raises a trap |

## Verification
The hardest cases to reach from the ports are the fused-operation sign rules. These cases need an infinite product, so an infinity in a or b and no zero or NaN in the other. They also need an infinite addend whose sign relation to the product decides validity. Random classes reach them only rarely. The directed list therefore walks both signs of product and addend for multiply-add and multiply-subtract, including a quiet-NaN factor that must not count as an infinite product. A second corner is a software write coinciding with an operation. It is reached by strobing both in one cycle with enables that differ from the held ones, so that a decision taken from the new enables would show at the outputs.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int NX    = 5;
    localparam int X_I   = 0;
    localparam int X_U   = 1;
    localparam int X_O   = 2;
    localparam int X_Z   = 3;
    localparam int X_V   = 4;

    localparam int NST    = 5;
    localparam int ST_INX = 0;
    localparam int ST_RND = 1;
    localparam int ST_DEN = 2;
    localparam int ST_UNF = 3;
    localparam int ST_OVF = 4;

    localparam int NOPND  = 3;
    localparam int NTIER  = 3;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fcls_e;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_DIV   = 3'd3,
        OP_FMADD = 3'd4,
        OP_FMSUB = 3'd5
    } fop_e;

    typedef struct packed {
        logic [2:0] cls;
        logic       neg;
    } fopnd_t;

    typedef logic [NX-1:0]  xvec_t;
    typedef logic [NST-1:0] stvec_t;

    typedef struct packed {
        logic  we;
        logic  qnan;
        xvec_t cause;
    } fdecide_t;

    function automatic logic is_zero(fopnd_t o);
        return o.cls == CLS_ZERO;
    endfunction

    function automatic logic is_num(fopnd_t o);
        return o.cls == CLS_NUM;
    endfunction

    function automatic logic is_inf(fopnd_t o);
        return o.cls == CLS_INF;
    endfunction

    function automatic logic is_snan(fopnd_t o);
        return o.cls == CLS_SNAN;
    endfunction

    function automatic logic is_fused(logic [2:0] op);
        return (op == OP_FMADD) || (op == OP_FMSUB);
    endfunction

    function automatic logic is_mul_like(logic [2:0] op);
        return (op == OP_MUL) || is_fused(op);
    endfunction

    // cause bit selected by each status tier, highest priority first
    function automatic int tier_bit(int t);
        case (t)
            0:       return X_O;
            1:       return X_U;
            default: return X_I;
        endcase
    endfunction

endpackage

// File: rtl/fpx_invalid_detect.sv
module fpx_invalid_detect
    import fpx_pkg::*;
#(
    parameter int NOPS = NOPND
) (
    input  logic [2:0]            op,
    input  fopnd_t [NOPS-1:0]     opnd,
    output logic                  invalid,
    output logic                  zdiv_case
);

    logic [NOPS-1:0] live;
    logic [NOPS-1:0] snan_hit;

    genvar gi;
    generate
        for (gi = 0; gi < NOPS; gi++) begin : g_opnd
            if (gi < 2) begin : g_always_used
                assign live[gi] = 1'b1;
            end else begin : g_fused_only
                assign live[gi] = is_fused(op);
            end
            assign snan_hit[gi] = live[gi] & is_snan(opnd[gi]);
        end
    endgenerate

    fopnd_t a, b, c;
    assign a = opnd[0];
    assign b = opnd[1];
    assign c = opnd[2];

    logic both_inf, both_zero, inf_by_zero;
    logic prod_inf, prod_neg, fused_clash;
    logic kind_bad;

    always_comb begin
        both_inf    = is_inf(a) & is_inf(b);
        both_zero   = is_zero(a) & is_zero(b);
        inf_by_zero = (is_inf(a) & is_zero(b)) | (is_zero(a) & is_inf(b));

        prod_inf    = (is_inf(a) | is_inf(b)) &
                      (is_inf(a) | is_num(a)) & (is_inf(b) | is_num(b));
        prod_neg    = a.neg ^ b.neg;
        fused_clash = 1'b0;
        if (prod_inf && is_inf(c)) begin
            if (op == OP_FMADD)
                fused_clash = (prod_neg != c.neg);
            else if (op == OP_FMSUB)
                fused_clash = (prod_neg == c.neg);
        end

        kind_bad = 1'b0;
        case (op)
            OP_ADD:  kind_bad = both_inf & (a.neg != b.neg);
            OP_SUB:  kind_bad = both_inf & (a.neg == b.neg);
            OP_DIV:  kind_bad = both_inf | both_zero;
            default: kind_bad = 1'b0;
        endcase
        if (is_mul_like(op))
            kind_bad = inf_by_zero | fused_clash;

        invalid   = (|snan_hit) | kind_bad;
        zdiv_case = (op == OP_DIV) & is_num(a) & is_zero(b);
    end

endmodule

// File: rtl/fpx_status_resolve.sv
module fpx_status_resolve
    import fpx_pkg::*;
(
    input  stvec_t raw,
    input  xvec_t  en,
    output xvec_t  pick
);

    logic [NTIER-1:0] tier_hit;

    assign tier_hit[0] = raw[ST_OVF] & en[X_O];
    assign tier_hit[1] = (raw[ST_UNF] | raw[ST_DEN]) & en[X_U];
    assign tier_hit[2] = (raw[ST_INX] | raw[ST_RND]) & en[X_I];

    always_comb begin
        pick = '0;
        for (int t = 0; t < NTIER; t++) begin
            if (tier_hit[t] && (pick == '0))
                pick[tier_bit(t)] = 1'b1;
        end
    end

endmodule

// File: rtl/fpx_ctrl_reg.sv
module fpx_ctrl_reg
    import fpx_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CAUSE_LSB = 0,
    parameter int EN_LSB    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic              op_done,
    input  xvec_t             op_cause,
    output logic [DATA_W-1:0] rdata,
    output xvec_t             en
);

    xvec_t cause_q;
    xvec_t en_q;

    genvar gi;
    generate
        for (gi = 0; gi < NX; gi++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    en_q[gi] <= 1'b0;
                else if (sw_we)
                    en_q[gi] <= sw_wdata[EN_LSB + gi];
            end

            always_ff @(posedge clk) begin
                if (rst)
                    cause_q[gi] <= 1'b0;
                else if (op_done)
                    cause_q[gi] <= op_cause[gi];
                else if (sw_we)
                    cause_q[gi] <= sw_wdata[CAUSE_LSB + gi];
            end
        end
    endgenerate

    logic unused_wbits;
    assign unused_wbits = ^sw_wdata;

    always_comb begin
        rdata                     = '0;
        rdata[CAUSE_LSB +: NX]    = cause_q;
        rdata[EN_LSB +: NX]       = en_q;
    end

    assign en = en_q;

endmodule

// File: rtl/fp_exc_arbiter.sv
module fp_exc_arbiter
    import fpx_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CAUSE_LSB = 0,
    parameter int EN_LSB    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [2:0]        a_cls,
    input  logic              a_neg,
    input  logic [2:0]        b_cls,
    input  logic              b_neg,
    input  logic [2:0]        c_cls,
    input  logic              c_neg,
    input  logic [NST-1:0]    raw_status,
    output logic              res_we,
    output logic              res_force_qnan,
    output logic              trap_req
);

    fopnd_t [NOPND-1:0] opnd;
    assign opnd[0] = '{cls: a_cls, neg: a_neg};
    assign opnd[1] = '{cls: b_cls, neg: b_neg};
    assign opnd[2] = '{cls: c_cls, neg: c_neg};

    logic     invalid, zdiv_case;
    xvec_t    en, resolved;
    fdecide_t dec;

    fpx_invalid_detect #(.NOPS(NOPND)) u_invalid (
        .op        (op_kind),
        .opnd      (opnd),
        .invalid   (invalid),
        .zdiv_case (zdiv_case)
    );

    fpx_status_resolve u_status (
        .raw  (raw_status),
        .en   (en),
        .pick (resolved)
    );

    always_comb begin
        dec = '0;
        if (!op_valid) begin
            dec = '0;
        end else if (invalid) begin
            if (en[X_V]) begin
                dec.cause[X_V] = 1'b1;
            end else begin
                dec.we   = 1'b1;
                dec.qnan = 1'b1;
            end
        end else if (zdiv_case && en[X_Z]) begin
            dec.cause[X_Z] = 1'b1;
        end else begin
            dec.cause = resolved;
            dec.we    = (resolved == '0);
        end
    end

    fpx_ctrl_reg #(
        .DATA_W    (DATA_W),
        .CAUSE_LSB (CAUSE_LSB),
        .EN_LSB    (EN_LSB)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (csr_we),
        .sw_wdata (csr_wdata),
        .op_done  (op_valid),
        .op_cause (dec.cause),
        .rdata    (csr_rdata),
        .en       (en)
    );

    assign res_we         = dec.we;
    assign res_force_qnan = dec.qnan;
    assign trap_req       = |dec.cause;

endmodule

// File: rtl/fp_exc_arbiter_chk.sv
module fp_exc_arbiter_chk
    import fpx_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CAUSE_LSB = 0,
    parameter int EN_LSB    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              csr_we,
    input logic [DATA_W-1:0] csr_rdata,
    input logic              op_valid,
    input logic [2:0]        a_cls,
    input logic              res_we,
    input logic              res_force_qnan,
    input logic              trap_req
);

    logic [DATA_W-1:0] impl_mask;
    always_comb begin
        impl_mask                  = '0;
        impl_mask[CAUSE_LSB +: NX] = '1;
        impl_mask[EN_LSB +: NX]    = '1;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (!res_we && !res_force_qnan && !trap_req));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata & ~impl_mask) == '0);

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !csr_we) |=> $stable(csr_rdata));

    a_r3_cause_tracks_trap: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> ((|csr_rdata[CAUSE_LSB +: NX]) == $past(trap_req)));

    a_r4_snan_traps: assert property (@(posedge clk) disable iff (rst)
        (op_valid && a_cls == CLS_SNAN && csr_rdata[EN_LSB + X_V]) |-> (trap_req && !res_we));

    a_r8_qnan_is_written: assert property (@(posedge clk) disable iff (rst)
        res_force_qnan |-> (res_we && !trap_req));

    a_r10_one_cause: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> $onehot0(csr_rdata[CAUSE_LSB +: NX]));

    a_r11_trap_no_write: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> !res_we);

endmodule

bind fp_exc_arbiter fp_exc_arbiter_chk #(
    .DATA_W    (DATA_W),
    .CAUSE_LSB (CAUSE_LSB),
    .EN_LSB    (EN_LSB)
) i_chk (
    .clk            (clk),
    .rst            (rst),
    .csr_we         (csr_we),
    .csr_rdata      (csr_rdata),
    .op_valid       (op_valid),
    .a_cls          (a_cls),
    .res_we         (res_we),
    .res_force_qnan (res_force_qnan),
    .trap_req       (trap_req)
);

// File: tb/test_fp_exc_arbiter.sv
module test_fp_exc_arbiter;

    localparam int C_ZERO = 0, C_NUM = 1, C_INF = 2, C_QNAN = 3, C_SNAN = 4;
    localparam int K_ADD = 0, K_SUB = 1, K_MUL = 2, K_DIV = 3, K_FMA = 4, K_FMS = 5;
    localparam logic [31:0] REG_MASK = 32'h0000_1F1F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [2:0]  a_cls = '0, b_cls = '0, c_cls = '0;
    logic        a_neg = 1'b0, b_neg = 1'b0, c_neg = 1'b0;
    logic [4:0]  raw_status = '0;
    logic        res_we, res_force_qnan, trap_req;

    always #2ns clk = ~clk;

    fp_exc_arbiter i_fp_exc_arbiter (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .op_valid(op_valid), .op_kind(op_kind),
        .a_cls(a_cls), .a_neg(a_neg), .b_cls(b_cls), .b_neg(b_neg),
        .c_cls(c_cls), .c_neg(c_neg), .raw_status(raw_status),
        .res_we(res_we), .res_force_qnan(res_force_qnan), .trap_req(trap_req)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] model_reg = '0;
    bit          finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference: returns {write, force_qnan, cause[4:0]}
    function automatic logic [6:0] expect_fn(int k, int ac, bit an, int bc, bit bn,
                                             int cc, bit cn, logic [4:0] st, logic [4:0] en);
        bit fused = (k == K_FMA) || (k == K_FMS);
        bit bad = (ac == C_SNAN) || (bc == C_SNAN) || (fused && cc == C_SNAN);
        bit p_inf;
        logic [4:0] cz = 5'b0;
        if (k == K_ADD && ac == C_INF && bc == C_INF && an != bn) bad = 1;
        if (k == K_SUB && ac == C_INF && bc == C_INF && an == bn) bad = 1;
        if ((k == K_MUL || fused) &&
            ((ac == C_INF && bc == C_ZERO) || (ac == C_ZERO && bc == C_INF))) bad = 1;
        if (k == K_DIV && ((ac == C_INF && bc == C_INF) || (ac == C_ZERO && bc == C_ZERO))) bad = 1;
        p_inf = (ac == C_INF || bc == C_INF) && (ac == C_INF || ac == C_NUM) &&
                (bc == C_INF || bc == C_NUM);
        if (fused && p_inf && cc == C_INF) begin
            if (k == K_FMA && ((an ^ bn) != cn)) bad = 1;
            if (k == K_FMS && ((an ^ bn) == cn)) bad = 1;
        end
        if (bad)
            return en[4] ? 7'b00_10000 : 7'b11_00000;
        if (k == K_DIV && ac == C_NUM && bc == C_ZERO && en[3])
            return 7'b00_01000;
        if (st[4] && en[2])              cz = 5'b00100;
        else if ((st[3] | st[2]) && en[1]) cz = 5'b00010;
        else if ((st[1] | st[0]) && en[0]) cz = 5'b00001;
        return {(cz == 5'b0), 1'b0, cz};
    endfunction

    always @(negedge clk) begin
        if (!rst && !finished)
            check("R3 register tracks model (R2 layout)", csr_rdata, model_reg);
    end

    task automatic set_op(int k, int ac, bit an, int bc, bit bn, int cc, bit cn, logic [4:0] st);
        op_valid = 1'b1;
        op_kind = 3'(k);
        a_cls = 3'(ac); a_neg = an;
        b_cls = 3'(bc); b_neg = bn;
        c_cls = 3'(cc); c_neg = cn;
        raw_status = st;
    endtask

    task automatic set_wr(logic [31:0] v);
        csr_we = 1'b1;
        csr_wdata = v;
    endtask

    task automatic step(input string tag);
        logic [6:0]  e;
        logic [31:0] nxt;
        #1ns;
        e = op_valid ? expect_fn(int'(op_kind), int'(a_cls), a_neg, int'(b_cls), b_neg,
                                 int'(c_cls), c_neg, raw_status, model_reg[12:8])
                     : 7'b0;
        check(tag, {29'b0, res_we, res_force_qnan, trap_req}, {29'b0, e[6], e[5], |e[4:0]});
        @(posedge clk);
        nxt = model_reg;
        if (csr_we)   nxt = csr_wdata & REG_MASK;
        if (op_valid) nxt[4:0] = e[4:0];
        model_reg = nxt;
        @(negedge clk);
        op_valid = 1'b0;
        csr_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset value", csr_rdata, 32'h0);
        step("R1 idle outputs quiet");

        set_wr(32'hFFFF_FFFF); step("R2 write all ones");
        check("R2 readback mask", csr_rdata, 32'h0000_1F1F);
        set_wr(32'h0000_1F00); step("R2 enable all traps");

        set_op(K_ADD, C_SNAN, 0, C_NUM, 0, C_ZERO, 0, 5'b0); step("R4 snan in a traps");
        check("R4 invalid cause recorded", csr_rdata, 32'h0000_1F10);
        set_op(K_FMA, C_NUM, 0, C_NUM, 0, C_SNAN, 0, 5'b0); step("R4 snan in addend traps");
        set_op(K_MUL, C_NUM, 0, C_NUM, 0, C_SNAN, 0, 5'b0); step("R4 unused c ignored");
        check("R4 unused c leaves no cause (R3 clear)", csr_rdata, 32'h0000_1F00);
        set_op(K_DIV, C_NUM, 0, C_SNAN, 1, C_NUM, 0, 5'b0); step("R4 snan in b traps");

        set_op(K_ADD, C_INF, 0, C_INF, 1, C_NUM, 0, 5'b0); step("R5 add +inf -inf");
        set_op(K_ADD, C_INF, 1, C_INF, 1, C_NUM, 0, 5'b0); step("R5 add -inf -inf ok");
        set_op(K_SUB, C_INF, 0, C_INF, 0, C_NUM, 0, 5'b0); step("R5 sub +inf +inf");
        set_op(K_SUB, C_INF, 0, C_INF, 1, C_NUM, 0, 5'b0); step("R5 sub +inf -inf ok");

        set_op(K_MUL, C_INF, 0, C_ZERO, 0, C_NUM, 0, 5'b0); step("R6 mul inf*0");
        set_op(K_MUL, C_ZERO, 1, C_INF, 0, C_NUM, 0, 5'b0); step("R6 mul 0*inf");
        set_op(K_DIV, C_INF, 0, C_INF, 1, C_NUM, 0, 5'b0); step("R6 div inf/inf");
        set_op(K_DIV, C_ZERO, 0, C_ZERO, 0, C_NUM, 0, 5'b0); step("R6 div 0/0");
        set_op(K_DIV, C_INF, 0, C_ZERO, 0, C_NUM, 0, 5'b0); step("R6 div inf/0 not invalid");
        set_op(K_FMS, C_INF, 0, C_ZERO, 0, C_NUM, 0, 5'b0); step("R6 fused inf*0");

        set_op(K_FMA, C_INF, 0, C_NUM, 0, C_INF, 1, 5'b0); step("R7 fma +prod -inf");
        set_op(K_FMA, C_INF, 1, C_NUM, 1, C_INF, 0, 5'b0); step("R7 fma +prod +inf ok");
        set_op(K_FMS, C_INF, 0, C_NUM, 0, C_INF, 0, 5'b0); step("R7 fms +prod +inf");
        set_op(K_FMS, C_NUM, 0, C_INF, 1, C_INF, 0, 5'b0); step("R7 fms -prod +inf ok");
        set_op(K_FMA, C_QNAN, 0, C_INF, 0, C_INF, 1, 5'b0); step("R7 nan product not inf");
        set_op(K_ADD, C_INF, 0, C_INF, 0, C_INF, 1, 5'b0); step("R7 c ignored for add");

        set_op(K_DIV, C_NUM, 0, C_ZERO, 0, C_NUM, 0, 5'b0); step("R9 div by zero traps");
        check("R9 zero-divide cause", csr_rdata, 32'h0000_1F08);
        set_wr(32'h0000_1700); step("R9 disable zero trap");
        set_op(K_DIV, C_NUM, 1, C_ZERO, 0, C_NUM, 0, 5'b0); step("R9 div by zero writes");
        check("R9 no cause when disabled", csr_rdata, 32'h0000_1700);

        set_wr(32'h0000_0F00); step("R8 disable invalid trap");
        set_op(K_ADD, C_SNAN, 0, C_NUM, 0, C_NUM, 0, 5'b11111); step("R8 qnan write");
        check("R8 no cause on quiet invalid", csr_rdata, 32'h0000_0F00);
        set_op(K_SUB, C_INF, 1, C_INF, 1, C_NUM, 0, 5'b0); step("R8 qnan write sub");

        set_wr(32'h0000_1F00); step("R10 all traps");
        set_op(K_ADD, C_NUM, 0, C_NUM, 0, C_NUM, 0, 5'b11111); step("R10 overflow wins");
        check("R10 overflow cause", csr_rdata, 32'h0000_1F04);
        set_wr(32'h0000_1B00); step("R10 overflow off");
        set_op(K_MUL, C_NUM, 0, C_NUM, 0, C_NUM, 0, 5'b11111); step("R10 underflow next");
        check("R10 underflow cause", csr_rdata, 32'h0000_1B02);
        set_op(K_MUL, C_NUM, 0, C_NUM, 0, C_NUM, 0, 5'b00100); step("R10 denormal as underflow");
        set_wr(32'h0000_1900); step("R10 underflow off");
        set_op(K_SUB, C_NUM, 0, C_NUM, 0, C_NUM, 0, 5'b11111); step("R10 inexact last");
        check("R10 inexact cause", csr_rdata, 32'h0000_1901);
        set_op(K_SUB, C_NUM, 0, C_NUM, 0, C_NUM, 0, 5'b00010); step("R10 rounded as inexact");
        set_wr(32'h0000_1800); step("R10 status traps off");
        set_op(K_ADD, C_NUM, 0, C_NUM, 0, C_NUM, 0, 5'b11111); step("R10 nothing enabled writes");

        set_wr(32'h0000_1F00); step("R3 enable all");
        set_op(K_ADD, C_SNAN, 0, C_NUM, 0, C_NUM, 0, 5'b0); step("R11 trap pulse");
        set_op(K_ADD, C_NUM, 0, C_NUM, 0, C_NUM, 0, 5'b0); step("R3 clean op");
        check("R3 causes cleared by clean op", csr_rdata, 32'h0000_1F00);

        set_wr(32'h0000_1000);
        set_op(K_ADD, C_SNAN, 0, C_NUM, 0, C_NUM, 0, 5'b0); step("R12 old enables decide");
        check("R12 merged value", csr_rdata, 32'h0000_1010);
        set_wr(32'h0000_1F00);
        set_op(K_ADD, C_NUM, 0, C_NUM, 0, C_NUM, 0, 5'b10000); step("R12 overflow not yet enabled");
        check("R12 enables loaded, no cause", csr_rdata, 32'h0000_1F00);

        for (int i = 0; i < 800; i++) begin
            if ($urandom_range(0, 7) == 0)
                set_wr({$urandom()} & 32'h0000_FFFF);
            if ($urandom_range(0, 5) != 0)
                set_op($urandom_range(0, 5), $urandom_range(0, 4), 1'($urandom_range(0, 1)),
                       $urandom_range(0, 4), 1'($urandom_range(0, 1)),
                       $urandom_range(0, 4), 1'($urandom_range(0, 1)),
                       5'($urandom_range(0, 31)));
            step("R11 random operation outcome");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule